// File: doc/BRIEF.md
# Four-Value Register Sorter

This block takes four unsigned values in a single load strobe, keeps them in four working registers, and rearranges them in place until they stand in non-decreasing order from lane 0 to lane 3. Three magnitude comparators watch the neighbouring lane pairs (0,1), (1,2) and (2,3). A small control machine steers a multiplexer in front of each lane register, so that on a swap step each out-of-order neighbour pair trades contents.

Swap steps alternate between the even group of pairs, (0,1) together with (2,3), and the odd pair (1,2). The first step after a load always uses the even group. Comparator results are captured in a flag register, so every swap step is followed by a refresh step that compares the updated lanes again. Input that is already in order completes one clock after the load. The slowest inputs need four swap steps and four refresh steps, which is eight clocks, or 80 ns at 100 MHz. A host pulses the start input with the four values applied, waits for done, and then reads the four outputs. The outputs keep their values until the next accepted start.

Top module: `quad_sorter`

## Requirements
- R1: While reset is high and after it is released, done is 0 and all four outputs are 0 until the first start is accepted.
- R2: A start seen at a clock edge while the block is idle (never sorting, or done high) captures din0..din3 into lanes 0..3. When that input is not already in order, done reads 0 after that edge.
- R3: When done is high, dout0 <= dout1 <= dout2 <= dout3. The four outputs are exactly the four captured inputs, with each value appearing as often as it did at the input.
- R4: If the captured values are already non-decreasing, done goes high at the first clock edge after the capturing edge.
- R5: Otherwise, done goes high 2*P edges after the capturing edge. P is the number of alternating steps needed to sort the values: the even step swaps every out-of-order pair among (0,1) and (2,3), the odd step swaps pair (1,2) if it is out of order, and the sequence starts with an even step. An even step that finds nothing to swap still counts. 2*P never exceeds 8.
- R6: A pair whose two values are equal counts as ordered and is never exchanged. An input made only of ties in non-decreasing order completes in 1 cycle.
- R7: A start that arrives while a sort is running is ignored. The running sort finishes with its original values and latency.
- R8: After done rises, done and all outputs hold steady for as long as start stays low, whatever din0..din3 do.
- R9: During a sort, every step keeps the same four values in the lanes, so the sum of the outputs stays constant on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load strobe; sampled only while idle |
| din0 | input | WIDTH | Value captured into lane 0 |
| din1 | input | WIDTH | Value captured into lane 1 |
| din2 | input | WIDTH | Value captured into lane 2 |
| din3 | input | WIDTH | Value captured into lane 3 |
| dout0 | output | WIDTH | Lane 0 register (smallest when done) |
| dout1 | output | WIDTH | Lane 1 register |
| dout2 | output | WIDTH | Lane 2 register |
| dout3 | output | WIDTH | Lane 3 register (largest when done) |
| done | output | 1 | High once the lanes are in order; cleared by the next accepted start |

## Verification
The hardest cases to reach are the few orderings that need all four alternating steps, and a start that lands in the middle of one of them. Steps that find nothing to swap still cost cycles, so latency is hard to predict from the input alone. A sweep over every combination of four 3-bit values reaches all of these orderings. For each input the bench computes the step count from the alternation rule and the sorted list by counting values. Directed runs inject a second start one cycle into a worst-case sort, and watch the output sum on every cycle of a run.

// File: rtl/sorter_pkg.sv
package sorter_pkg;

  localparam int LANES = 4;
  localparam int PAIRS = LANES - 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SWAP,
    ST_REFRESH
  } sort_state_t;

  typedef enum logic [1:0] {
    SEL_HOLD,
    SEL_LOAD,
    SEL_UP,
    SEL_DOWN
  } lane_sel_t;

endpackage

// File: rtl/sorter_cmp.sv
module sorter_cmp #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] lo_val,
  input  logic [WIDTH-1:0] hi_val,
  output logic             inverted
);

  // Strictly greater: ties count as ordered, which keeps equal keys in place.
  assign inverted = (lo_val > hi_val);

endmodule

// File: rtl/sorter_lane.sv
module sorter_lane
  import sorter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  lane_sel_t        sel,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] up_val,
  input  logic [WIDTH-1:0] down_val,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      case (sel)
        SEL_LOAD: q <= load_val;
        SEL_UP:   q <= up_val;
        SEL_DOWN: q <= down_val;
        default:  q <= q;
      endcase
    end
  end

endmodule

// File: rtl/sorter_ctrl.sv
module sorter_ctrl
  import sorter_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PAIRS-1:0] inverted,
  output lane_sel_t        sel [LANES],
  output logic             use_input,
  output logic             busy,
  output logic             done
);

  sort_state_t      state;
  logic [PAIRS-1:0] flag_q;
  logic             even_q;
  logic [PAIRS-1:0] even_mask;
  logic [PAIRS-1:0] odd_mask;
  logic [PAIRS-1:0] swap_en;
  logic             accept;

  always_comb begin
    for (int p = 0; p < PAIRS; p++) begin
      even_mask[p] = ((p & 1) == 0);
      odd_mask[p]  = ((p & 1) == 1);
    end
  end

  assign accept    = (state == ST_IDLE) && start;
  assign use_input = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign swap_en   = (state == ST_SWAP) ? (flag_q & (even_q ? even_mask : odd_mask)) : '0;

  // Pairs within one step are disjoint, so no lane gets two selects.
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      sel[l] = accept ? SEL_LOAD : SEL_HOLD;
    end
    for (int p = 0; p < PAIRS; p++) begin
      if (swap_en[p]) begin
        sel[p]   = SEL_UP;
        sel[p+1] = SEL_DOWN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      flag_q <= '0;
      even_q <= 1'b1;
      done   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            flag_q <= inverted;
            even_q <= 1'b1;
            done   <= 1'b0;
            state  <= ST_SWAP;
          end
        end
        ST_SWAP: begin
          if (flag_q == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            even_q <= ~even_q;
            state  <= ST_REFRESH;
          end
        end
        ST_REFRESH: begin
          flag_q <= inverted;
          if (inverted == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_SWAP;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/quad_sorter.sv
module quad_sorter
  import sorter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] din0,
  input  logic [WIDTH-1:0] din1,
  input  logic [WIDTH-1:0] din2,
  input  logic [WIDTH-1:0] din3,
  output logic [WIDTH-1:0] dout0,
  output logic [WIDTH-1:0] dout1,
  output logic [WIDTH-1:0] dout2,
  output logic [WIDTH-1:0] dout3,
  output logic             done
);

  logic [WIDTH-1:0] in_v  [LANES];
  logic [WIDTH-1:0] cur_v [LANES];
  logic [WIDTH-1:0] opnd  [LANES];
  lane_sel_t        sel   [LANES];
  logic [PAIRS-1:0] inverted;
  logic             use_input;
  logic             busy;

  assign in_v[0] = din0;
  assign in_v[1] = din1;
  assign in_v[2] = din2;
  assign in_v[3] = din3;

  assign dout0 = cur_v[0];
  assign dout1 = cur_v[1];
  assign dout2 = cur_v[2];
  assign dout3 = cur_v[3];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WIDTH-1:0] up_src;
    logic [WIDTH-1:0] down_src;

    if (g == LANES - 1) begin : g_top_edge
      assign up_src = cur_v[g];
    end else begin : g_top_mid
      assign up_src = cur_v[g+1];
    end

    if (g == 0) begin : g_bot_edge
      assign down_src = cur_v[g];
    end else begin : g_bot_mid
      assign down_src = cur_v[g-1];
    end

    // Comparators see the incoming values at load time, the lanes otherwise.
    assign opnd[g] = use_input ? in_v[g] : cur_v[g];

    sorter_lane #(.WIDTH(WIDTH)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .sel      (sel[g]),
      .load_val (in_v[g]),
      .up_val   (up_src),
      .down_val (down_src),
      .q        (cur_v[g])
    );
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    sorter_cmp #(.WIDTH(WIDTH)) u_cmp (
      .lo_val   (opnd[p]),
      .hi_val   (opnd[p+1]),
      .inverted (inverted[p])
    );
  end

  sorter_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .inverted  (inverted),
    .sel       (sel),
    .use_input (use_input),
    .busy      (busy),
    .done      (done)
  );

endmodule

// File: rtl/quad_sorter_chk.sv
module quad_sorter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic             busy,
  input logic [WIDTH-1:0] dout0,
  input logic [WIDTH-1:0] dout1,
  input logic [WIDTH-1:0] dout2,
  input logic [WIDTH-1:0] dout3
);

  localparam int SUMW    = WIDTH + 2;
  localparam int MAX_RUN = 8;

  logic [SUMW-1:0] lane_sum;
  logic [3:0]      run_cnt;

  assign lane_sum = {2'b00, dout0} + {2'b00, dout1} + {2'b00, dout2} + {2'b00, dout3};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (busy) begin
      if (run_cnt != 4'hF) run_cnt <= run_cnt + 4'd1;
    end else begin
      run_cnt <= '0;
    end
  end

  // R3: outputs are ordered when done rises
  p_sorted_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (dout0 <= dout1) && (dout1 <= dout2) && (dout2 <= dout3));

  // R5: a sort never stays busy past eight cycles
  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_cnt < 4'(MAX_RUN)));

  // R8: finished result holds while start is low
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done && $stable(dout0) && $stable(dout1)
                         && $stable(dout2) && $stable(dout3));

  // R9: each sort step preserves the lane contents as a set
  p_conserve_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> (lane_sum == $past(lane_sum)));

  // R7: a start during a sort does not reload the lanes
  p_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (lane_sum == $past(lane_sum)));

endmodule

bind quad_sorter quad_sorter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .done  (done),
  .busy  (busy),
  .dout0 (dout0),
  .dout1 (dout1),
  .dout2 (dout2),
  .dout3 (dout3)
);

// File: tb/sim_quad_sorter.sv
module sim_quad_sorter;

  localparam int W          = 3;
  localparam int CLK_PERIOD = 10;
  localparam int VMAX       = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] din0 = '0, din1 = '0, din2 = '0, din3 = '0;
  logic [W-1:0] dout0, dout1, dout2, dout3;
  logic         done;

  int total_checks = 0;
  int bad_checks   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  quad_sorter #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .din0(din0), .din1(din1), .din2(din2), .din3(din3),
    .dout0(dout0), .dout1(dout1), .dout2(dout2), .dout3(dout3),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pack4(input int a, input int b, input int c, input int d);
    return (a << (3 * W)) | (b << (2 * W)) | (c << W) | d;
  endfunction

  // Sorted list by counting each value in turn.
  function automatic int expect_sorted(input int a, input int b, input int c, input int d);
    int outv[4];
    int n = 0;
    for (int x = 0; x <= VMAX; x++) begin
      if (a == x) begin outv[n] = x; n++; end
      if (b == x) begin outv[n] = x; n++; end
      if (c == x) begin outv[n] = x; n++; end
      if (d == x) begin outv[n] = x; n++; end
    end
    return pack4(outv[0], outv[1], outv[2], outv[3]);
  endfunction

  // Latency from the alternating-step rule.
  function automatic int expect_latency(input int a, input int b, input int c, input int d);
    int v[4];
    int steps = 0;
    bit even = 1'b1;
    v[0] = a; v[1] = b; v[2] = c; v[3] = d;
    while (!(v[0] <= v[1] && v[1] <= v[2] && v[2] <= v[3]) && steps < 20) begin
      for (int k = (even ? 0 : 1); k < 3; k += 2) begin
        if (v[k] > v[k+1]) begin
          int t = v[k];
          v[k] = v[k+1];
          v[k+1] = t;
        end
      end
      even = !even;
      steps++;
    end
    return (steps == 0) ? 1 : 2 * steps;
  endfunction

  task automatic run_case(input int a, input int b, input int c, input int d,
                          input bit inject, input bit track_sum, output int lat);
    int in_sum = a + b + c + d;
    @(negedge clk);
    din0 = W'(a); din1 = W'(b); din2 = W'(c); din3 = W'(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (track_sum)
        check(int'(dout0) + int'(dout1) + int'(dout2) + int'(dout3) == in_sum,
              "R9 lane sum constant", int'(dout0) + int'(dout1) + int'(dout2) + int'(dout3), in_sum);
      if (done) begin
        lat = i;
        break;
      end
      if (inject && i == 1) begin
        start = 1'b1;
        din0 = '0; din1 = W'(VMAX); din2 = '0; din3 = W'(VMAX);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R5 watchdog expired", 200000, 0);
    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

  initial begin
    int lat;
    int got;
    int exp;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done during reset", done, 0);
    check(pack4(dout0, dout1, dout2, dout3) == 0, "R1 outputs during reset",
          pack4(dout0, dout1, dout2, dout3), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(pack4(dout0, dout1, dout2, dout3) == 0, "R1 outputs after reset",
          pack4(dout0, dout1, dout2, dout3), 0);

    // Exhaustive sweep over all 3-bit quadruples: R3, R4, R5
    for (int a = 0; a <= VMAX; a++) begin
      for (int b = 0; b <= VMAX; b++) begin
        for (int c = 0; c <= VMAX; c++) begin
          for (int d = 0; d <= VMAX; d++) begin
            run_case(a, b, c, d, 1'b0, 1'b0, lat);
            got = pack4(dout0, dout1, dout2, dout3);
            exp = expect_sorted(a, b, c, d);
            check(got == exp, "R3 sorted contents", got, exp);
            exp = expect_latency(a, b, c, d);
            if (exp == 1) check(lat == 1, "R4 ordered input latency", lat, 1);
            else          check(lat == exp, "R5 step latency", lat, exp);
            check(lat >= 1 && lat <= 8, "R5 latency bound", lat, 8);
          end
        end
      end
    end

    // R6: ties count as ordered
    run_case(5, 5, 5, 5, 1'b0, 1'b0, lat);
    check(lat == 1, "R6 all-equal latency", lat, 1);
    run_case(2, 2, 6, 6, 1'b0, 1'b0, lat);
    check(lat == 1, "R6 paired ties latency", lat, 1);
    run_case(3, 3, 1, 1, 1'b0, 1'b0, lat);
    exp = expect_latency(3, 3, 1, 1);
    check(lat == exp, "R6 ties out of order latency", lat, exp);
    check(pack4(dout0, dout1, dout2, dout3) == pack4(1, 1, 3, 3), "R6 ties result",
          pack4(dout0, dout1, dout2, dout3), pack4(1, 1, 3, 3));

    // R7: start during a worst-case sort is ignored
    run_case(7, 6, 5, 4, 1'b1, 1'b0, lat);
    check(lat == 8, "R7 latency with busy start", lat, 8);
    check(pack4(dout0, dout1, dout2, dout3) == pack4(4, 5, 6, 7), "R7 result with busy start",
          pack4(dout0, dout1, dout2, dout3), pack4(4, 5, 6, 7));

    // R9: lane sum on every cycle of a slow sort
    run_case(6, 4, 2, 0, 1'b0, 1'b1, lat);
    check(lat == 8, "R9 run latency", lat, 8);

    // R8: hold while start stays low and inputs wander
    din0 = 3'd1; din1 = 3'd0; din2 = 3'd7; din3 = 3'd2;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      din0 = W'(k + 2);
      check(done == 1'b1, "R8 done holds", done, 1);
      check(pack4(dout0, dout1, dout2, dout3) == pack4(0, 2, 4, 6), "R8 outputs hold",
            pack4(dout0, dout1, dout2, dout3), pack4(0, 2, 4, 6));
    end

    // R2: restart from done clears done after the capturing edge
    @(negedge clk);
    din0 = 3'd7; din1 = 3'd1; din2 = 3'd1; din3 = 3'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2 done cleared on restart", done, 0);
    check(pack4(dout0, dout1, dout2, dout3) == pack4(7, 1, 1, 0), "R2 lanes captured",
          pack4(dout0, dout1, dout2, dout3), pack4(7, 1, 1, 0));
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R2 restart completes", done, 1);
    check(pack4(dout0, dout1, dout2, dout3) == pack4(0, 1, 1, 7), "R2 restart result",
          pack4(dout0, dout1, dout2, dout3), pack4(0, 1, 1, 7));

    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

endmodule